// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block is the receive half of a synchronous serial master. It generates the shift clock from an 8-bit baud divider and samples one data line on each high-to-low transition of that clock. Bits arrive least significant first. Each word is 8 or 9 bits long and is built up in a shift register. When its last bit has been sampled, the word moves into a two-entry receive FIFO. The ninth bit is stored with its byte in the same entry.

Reception begins only when the port and master mode are both enabled and either the one-shot enable or the continuous enable is active. A one-shot request fetches a single word and then clears itself. A continuous enable keeps words streaming back to back until it is dropped. If both are active, the continuous enable governs.

A word that completes while both FIFO entries are occupied is discarded and raises an overrun. The overrun stops all further clocking and transfers until the continuous enable is taken away. The host reads data with a one-cycle pop strobe. It should read the ninth-bit status before popping, because a pop moves the status on to the next entry. A ready flag and an interrupt output gated by an enable report pending data.

Top module: `sync_rx_master`

## Requirements
- R1: After reset, and in the cycle after any cycle in which `port_en` is low, `sclk` is 0, the FIFO is empty (`rx_ready` 0), `overrun` is 0, `single_busy` is 0 and `rx_data` is 0.
- R2: The clock starts only while `port_en` and `master_en` are both 1 and either `cont_en` or the one-shot request state (`single_busy`) is 1. Otherwise `sclk` stays low.
- R3: `sclk` idles low. Each bit takes one full clock period of 4·(`baud_div`+1) system clocks, of which the first 2·(`baud_div`+1) are high.
- R4: `sdata` is sampled at each high-to-low transition of `sclk`. The first sampled bit is bit 0 of the word. With `nine_bit_en` 0, a word is 8 bits and `rx_data` returns them.
- R5: With `nine_bit_en` 1, a word is 9 bits and its last bit is the ninth bit. `rx_bit9` shows the ninth bit of the FIFO head while the FIFO is non-empty, and 0 when it is empty.
- R6: A one-cycle `single_req` sets `single_busy`. Exactly one word is then received, `single_busy` clears when that word's last bit is taken, and no further `sclk` rising edge follows.
- R7: With `cont_en` 1, words follow back to back with no gap until `cont_en` drops. If `cont_en` and the one-shot request are both active, reception carries on past the first word.
- R8: The FIFO holds two words and returns them oldest first. `rx_ready` is 1 exactly while it holds at least one word.
- R9: A word completing while the FIFO holds two words is discarded and sets `overrun`. While `overrun` is 1, `sclk` produces no rising edge and no word enters the FIFO.
- R10: `overrun` clears in the cycle after `cont_en` is seen going from 1 to 0. The words held in the FIFO remain readable afterwards.
- R11: `rd_strobe` pops the FIFO head into `rx_data`, which is valid from the next cycle. A strobe while the FIFO is empty leaves `rx_data` and all flags unchanged.
- R12: `irq` is 1 exactly when `rx_ready` and `int_en` are both 1.
- R13: When a pop and a word completion fall in the same cycle with two words held, the popped slot counts as free. The new word is stored and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Serial port enable; low clears the block |
| master_en | input | 1 | Synchronous master mode select |
| cont_en | input | 1 | Continuous receive enable |
| single_req | input | 1 | One-cycle request for a single word |
| nine_bit_en | input | 1 | Selects 9-bit words |
| int_en | input | 1 | Interrupt enable |
| baud_div | input | DIV_W | Baud divider value |
| rd_strobe | input | 1 | Pop strobe for the FIFO head |
| sdata | input | 1 | Serial data line |
| sclk | output | 1 | Generated shift clock |
| rx_data | output | DATA_W | Last popped data byte |
| rx_bit9 | output | 1 | Ninth bit of the FIFO head |
| rx_ready | output | 1 | FIFO holds at least one word |
| irq | output | 1 | Receive interrupt |
| overrun | output | 1 | Overrun error |
| single_busy | output | 1 | One-shot request pending |

## Verification
A host pop and a word landing in the FIFO can fall in the same cycle. This matters most when both FIFO entries are full, because then the pop decides whether the incoming word overruns. The bench fills the FIFO and counts shift-clock rising edges until the third word's last bit. It then places the pop strobe exactly on the clock edge where that bit is sampled. The test passes when no overrun appears, the popped value is the oldest word, and the next two reads return the second and third words in order.

// File: rtl/sync_rx_master.sv
module sync_rx_master #(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              master_en,
  input  logic              cont_en,
  input  logic              single_req,
  input  logic              nine_bit_en,
  input  logic              int_en,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              rd_strobe,
  input  logic              sdata,
  output logic              sclk,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_ready,
  output logic              irq,
  output logic              overrun,
  output logic              single_busy
);
  localparam int WORD_W = DATA_W + 1;
  localparam int BC_W   = $clog2(WORD_W + 1);

  logic              busy, sclk_q, nine_q, single_q, overrun_q, cont_q, head;
  logic [DIV_W:0]    cnt;
  logic [BC_W-1:0]   bitcnt;
  logic [WORD_W-1:0] shreg, shreg_nx;
  logic [WORD_W-1:0] mem [2];
  logic [1:0]        count;
  logic [DATA_W-1:0] data_q;

  wire [DIV_W:0]  half_m1   = {baud_div, 1'b1};
  wire [BC_W-1:0] nbits     = nine_q ? BC_W'(WORD_W) : BC_W'(DATA_W);
  wire            run       = master_en & (cont_en | single_q) & ~overrun_q;
  wire            last_tick = busy & (cnt == half_m1);
  wire            word_done = last_tick & sclk_q & (bitcnt == nbits - 1'b1);
  wire            pop       = rd_strobe & (count != 2'd0);
  wire            room      = (count != 2'd2) | pop;
  wire            push      = word_done & room;
  wire            ovf       = word_done & ~room;
  wire            abort     = busy & ~run & (bitcnt != nbits);
  wire            wr_slot   = head ^ count[0];

  always_comb begin
    shreg_nx = shreg;
    for (int i = 0; i < WORD_W; i++)
      if (bitcnt == BC_W'(i)) shreg_nx[i] = sdata;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cont_q <= 1'b0;
    else        cont_q <= cont_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; sclk_q <= 1'b0; nine_q <= 1'b0; cnt <= '0; bitcnt <= '0;
      shreg <= '0; single_q <= 1'b0; overrun_q <= 1'b0;
    end else if (!port_en) begin
      busy <= 1'b0; sclk_q <= 1'b0; nine_q <= 1'b0; cnt <= '0; bitcnt <= '0;
      shreg <= '0; single_q <= 1'b0; overrun_q <= 1'b0;
    end else begin
      if (word_done)        single_q <= 1'b0;
      else if (single_req)  single_q <= 1'b1;

      if (ovf)                                  overrun_q <= 1'b1;
      else if (overrun_q && !cont_en && cont_q) overrun_q <= 1'b0;

      if (!busy) begin
        if (run) begin
          busy <= 1'b1; sclk_q <= 1'b1; cnt <= '0; bitcnt <= '0;
          shreg <= '0; nine_q <= nine_bit_en;
        end
      end else if (abort) begin
        busy <= 1'b0; sclk_q <= 1'b0; cnt <= '0;
      end else if (last_tick) begin
        cnt <= '0;
        if (sclk_q) begin
          sclk_q <= 1'b0;
          shreg  <= shreg_nx;
          bitcnt <= bitcnt + 1'b1;
        end else if (bitcnt == nbits) begin
          if (run) begin
            sclk_q <= 1'b1; bitcnt <= '0; shreg <= '0; nine_q <= nine_bit_en;
          end else begin
            busy <= 1'b0;
          end
        end else begin
          sclk_q <= 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem[0] <= '0; mem[1] <= '0; head <= 1'b0; count <= '0; data_q <= '0;
    end else if (!port_en) begin
      mem[0] <= '0; mem[1] <= '0; head <= 1'b0; count <= '0; data_q <= '0;
    end else begin
      if (push) mem[wr_slot] <= shreg_nx;
      if (pop) begin
        data_q <= mem[head][DATA_W-1:0];
        head   <= ~head;
      end
      count <= count + 2'(push) - 2'(pop);
    end
  end

  assign sclk        = sclk_q;
  assign rx_data     = data_q;
  assign rx_ready    = (count != 2'd0);
  assign rx_bit9     = rx_ready & mem[head][DATA_W];
  assign irq         = rx_ready & int_en;
  assign overrun     = overrun_q;
  assign single_busy = single_q;
endmodule

// File: rtl/sync_rx_master_chk.sv
module sync_rx_master_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              port_en,
  input logic              master_en,
  input logic              rd_strobe,
  input logic              sclk,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_ready,
  input logic              irq,
  input logic              overrun,
  input logic              single_busy
);
  // R1
  port_off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (!sclk && !rx_ready && !overrun && !single_busy));

  // R2
  no_master_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |=> !$rose(sclk));

  // R9
  overrun_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> rx_ready);

  // R9
  overrun_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> !$rose(sclk));

  // R11
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && !rx_ready && rd_strobe) |=> $stable(rx_data));

  // R12
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> !irq);

  // R6
  single_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(single_busy) && $past(port_en)) |-> rx_ready);
endmodule

bind sync_rx_master sync_rx_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .master_en(master_en),
  .rd_strobe(rd_strobe), .sclk(sclk), .rx_data(rx_data), .rx_ready(rx_ready),
  .irq(irq), .overrun(overrun), .single_busy(single_busy)
);

// File: tb/sync_rx_master_bench.sv
module sync_rx_master_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic port_en = 1'b0, master_en = 1'b0, cont_en = 1'b0, single_req = 1'b0;
  logic nine_bit_en = 1'b0, int_en = 1'b0, rd_strobe = 1'b0, sdata = 1'b0;
  logic [7:0] baud_div = 8'd0;
  logic sclk, rx_bit9, rx_ready, irq, overrun, single_busy;
  logic [7:0] rx_data;

  int checks = 0, fails = 0;
  logic qbits [0:4095];
  int qrd = 0, qwr = 0;
  logic sclk_prev = 1'b0;

  always #5 clk = ~clk;

  sync_rx_master u_sync_rx_master (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .master_en(master_en),
    .cont_en(cont_en), .single_req(single_req), .nine_bit_en(nine_bit_en),
    .int_en(int_en), .baud_div(baud_div), .rd_strobe(rd_strobe), .sdata(sdata),
    .sclk(sclk), .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_ready(rx_ready),
    .irq(irq), .overrun(overrun), .single_busy(single_busy)
  );

  always @(negedge clk) begin
    if (sclk && !sclk_prev) begin
      sdata = qbits[qrd % 4096];
      qrd = qrd + 1;
    end
    sclk_prev = sclk;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic flush();
    qwr = qrd;
  endtask

  task automatic push_word(input logic [8:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      qbits[qwr % 4096] = w[i];
      qwr++;
    end
  endtask

  task automatic quiesce();
    cont_en = 1'b0; single_req = 1'b0; rd_strobe = 1'b0;
    repeat (12) @(negedge clk);
    port_en = 1'b0;
    @(negedge clk);
    port_en = 1'b1;
    flush();
  endtask

  task automatic read_word(input logic [8:0] w, input logic nine, input string tag);
    int t = 0;
    while (!rx_ready && t < 3000) begin @(negedge clk); t++; end
    chk(rx_ready, {tag, " ready"}, rx_ready, 1);
    if (nine) chk(rx_bit9 == w[8], {tag, " bit9"}, rx_bit9, w[8]);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    chk(rx_data == w[7:0], {tag, " data"}, rx_data, w[7:0]);
  endtask

  task automatic count_rises(input int cycles, output int n);
    logic p = sclk;
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (sclk && !p) n++;
      p = sclk;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n, t0, t1, t2, tcy;
    logic p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!sclk && !rx_ready && !overrun && !single_busy && rx_data == 0, "R1 reset",
        {sclk, rx_ready, overrun, single_busy}, 0);

    // R2: no clock without master mode or without an enable
    port_en = 1'b1; cont_en = 1'b1; master_en = 1'b0;
    count_rises(100, n);
    chk(n == 0, "R2 no master", n, 0);
    master_en = 1'b1; cont_en = 1'b0;
    count_rises(100, n);
    chk(n == 0, "R2 no enable", n, 0);

    // R3: timing sweep over divider values
    for (int d = 0; d < 4; d++) begin
      quiesce();
      baud_div = 8'(d);
      cont_en = 1'b1;
      n = 0; tcy = 0; p = sclk; t0 = 0; t1 = 0; t2 = 0;
      while (n < 3 && tcy < 2000) begin
        @(negedge clk); tcy++;
        if (sclk && !p) begin n++; if (n == 2) t0 = tcy; if (n == 3) t2 = tcy; end
        if (!sclk && p && n == 2) t1 = tcy;
        p = sclk;
      end
      chk(t1 - t0 == 2 * (d + 1), "R3 high time", t1 - t0, 2 * (d + 1));
      chk(t2 - t0 == 4 * (d + 1), "R3 period", t2 - t0, 4 * (d + 1));
    end

    // R4 R7 R8: every byte value, continuous 8-bit, divider 0
    quiesce();
    baud_div = 8'd0;
    for (int v = 0; v < 256; v++) push_word(9'(v), 8);
    cont_en = 1'b1;
    for (int v = 0; v < 256; v++) read_word(9'(v), 1'b0, "R4 R7 byte sweep");
    quiesce();

    // R5: 9-bit words, ninth bit checked before the pop
    nine_bit_en = 1'b1; baud_div = 8'd1;
    for (int v = 0; v < 64; v++) push_word(9'((v * 37 + 5) ^ ((v & 1) << 8)), 9);
    cont_en = 1'b1;
    for (int v = 0; v < 64; v++) read_word(9'((v * 37 + 5) ^ ((v & 1) << 8)), 1'b1, "R5 nine-bit");
    cont_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(!rx_bit9 || rx_ready, "R5 bit9 zero when empty", rx_bit9, 0);
    quiesce();
    nine_bit_en = 1'b0; baud_div = 8'd0;

    // R6: single word
    push_word(9'h05A, 8); push_word(9'h0FF, 8);
    single_req = 1'b1; @(negedge clk); single_req = 1'b0;
    chk(single_busy, "R6 request held", single_busy, 1);
    tcy = 0;
    while (!rx_ready && tcy < 500) begin @(negedge clk); tcy++; end
    chk(!single_busy, "R6 self clear", single_busy, 0);
    count_rises(200, n);
    chk(n == 0, "R6 one word only", n, 0);
    read_word(9'h05A, 1'b0, "R6 single data");
    quiesce();

    // R7: both enables, continuous wins
    push_word(9'h011, 8); push_word(9'h022, 8); push_word(9'h033, 8);
    cont_en = 1'b1; single_req = 1'b1; @(negedge clk); single_req = 1'b0;
    read_word(9'h011, 1'b0, "R7 both w0");
    read_word(9'h022, 1'b0, "R7 both w1");
    read_word(9'h033, 1'b0, "R7 both w2");
    quiesce();

    // R9 R10 R11 R12: overrun and recovery
    push_word(9'h0A1, 8); push_word(9'h0B2, 8); push_word(9'h0C3, 8);
    cont_en = 1'b1;
    tcy = 0;
    while (!overrun && tcy < 500) begin @(negedge clk); tcy++; end
    chk(overrun, "R9 overrun set", overrun, 1);
    chk(rx_ready, "R8 ready while full", rx_ready, 1);
    count_rises(60, n);
    chk(n == 0, "R9 clock stopped", n, 0);
    int_en = 1'b1; @(negedge clk);
    chk(irq, "R12 irq on", irq, 1);
    int_en = 1'b0; @(negedge clk);
    chk(!irq, "R12 irq masked", irq, 0);
    chk(overrun, "R10 overrun sticky", overrun, 1);
    cont_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(!overrun, "R10 overrun cleared", overrun, 0);
    read_word(9'h0A1, 1'b0, "R10 keep w0");
    read_word(9'h0B2, 1'b0, "R10 keep w1");
    chk(!rx_ready, "R9 third word dropped", rx_ready, 0);
    int_en = 1'b1;
    rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
    chk(rx_data == 8'hB2, "R11 empty read data", rx_data, 8'hB2);
    chk(!rx_ready && !overrun, "R11 empty read flags", {rx_ready, overrun}, 0);
    chk(!irq, "R12 irq empty", irq, 0);
    int_en = 1'b0;
    quiesce();

    // R13: pop in the same cycle the third word lands
    push_word(9'h04D, 8); push_word(9'h06E, 8); push_word(9'h07F, 8);
    cont_en = 1'b1;
    n = 0; p = sclk; tcy = 0;
    while (n < 24 && tcy < 1000) begin
      @(negedge clk); tcy++;
      if (sclk && !p) n++;
      p = sclk;
    end
    @(negedge clk);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0; cont_en = 1'b0;
    chk(rx_data == 8'h4D, "R13 popped oldest", rx_data, 8'h4D);
    chk(!overrun, "R13 no overrun", overrun, 0);
    read_word(9'h06E, 1'b0, "R13 w1");
    read_word(9'h07F, 1'b0, "R13 w2");
    chk(!rx_ready, "R13 drained", rx_ready, 0);

    // R1: port disable clears held data
    quiesce();
    push_word(9'h099, 8);
    cont_en = 1'b1;
    read_word(9'h099, 1'b0, "R1 prep");
    tcy = 0;
    while (!rx_ready && tcy < 500) begin @(negedge clk); tcy++; end
    port_en = 1'b0; @(negedge clk);
    chk(!rx_ready && !sclk && rx_data == 0 && !overrun, "R1 port off",
        {rx_ready, sclk, overrun}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule